// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Master

This controller sits between a simple request port and a three-wire serial EEPROM that stores 16-bit words at 8-bit addresses. A host presents a read or write request with a valid/ready handshake. The controller turns the request into serial command frames on chip-select, serial clock and data-out, samples data-in, and signals completion with a one-cycle done pulse. Read data stays on its port after that pulse.

Each serial bit takes three phases of equal length. The phase length is a parameter counted in system clocks. A read is one frame: 11 command bits, then 16 clocked input bits. A write runs as one fixed sequence: an enable command, the 27-bit program frame, a ready poll with chip-select active and the clock idle, and then a disable command. Chip-select drops between each step and the next. If the ready poll outlasts a parameterised number of phases, the sequence still finishes with the disable command and the request completes with an error flag.

Top module: `uwire_eeprom_master`

## Requirements
- R1: A command frame starts with a 1 bit, then a 2-bit opcode, then the 8-bit address, all sent MSB first. The read opcode is 10 and the write opcode is 01.
- R2: A read sends 11 command bits and then gives 16 more clock pulses. Data-in is sampled while the clock is high, and the bits are assembled MSB first into `rdata_o`, which is valid when `done_o` pulses.
- R3: Each bit has three phases with chip-select held high: data placed with the clock low, clock high, clock low. Data-out does not change while the clock is high, and the clock is never high while chip-select is low.
- R4: Every write begins with an enable frame of 11 bits, 1, 0, 0 followed by eight 1 bits, and chip-select then drops.
- R5: The program frame is 27 bits: 1, opcode 01, 8 address bits, 16 data bits. Chip-select drops after it.
- R6: After the program frame, chip-select goes high again with no clock pulses. It stays high until data-in reads high, and then drops.
- R7: After the ready poll, a disable frame of 11 bits (a 1 followed by ten 0 bits) is sent, and chip-select then drops.
- R8: Chip-select stays low for at least three phase lengths (one bit period) between any two commands.
- R9: `req_ready_o` is high when idle. It goes low in the cycle after a request is accepted and stays low until the cycle in which `done_o` pulses. `done_o` is high for exactly one cycle.
- R10: `rdata_o` changes only in the cycle where `done_o` is high, so a read result is held through later write requests.
- R11: If data-in is still low after POLL_TO poll phases, the disable frame is still sent and `err_o` is high when `done_o` pulses. `err_o` clears when the next request is accepted.
- R12: After reset, chip-select, clock and data-out are low, `req_ready_o` is high, and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Word to program |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Last word read |
| err_o | output | 1 | Ready poll timed out on the last write |
| cs_o | output | 1 | Serial chip-select, active high |
| sk_o | output | 1 | Serial clock |
| do_o | output | 1 | Serial data to the device |
| di_i | input | 1 | Serial data from the device, also its ready indication |

## Verification
The assertions assume that data-in is stable while the serial clock is high. They also assume a device that answers only when selected. The bench device model changes data-in only on the falling edge of the serial clock, or while it is busy outside a clocked frame, so its input stays inside that assumption. Host requests are raised only when `req_ready_o` is high and are held for one cycle, which is the only case that the handshake assertions cover. The ready poll is run both with a device that becomes ready and with one that never does, so both exits from the poll are covered.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_CMD, ST_RD_GAP, ST_WEN_CMD, ST_WEN_GAP, ST_WR_CMD,
    ST_WR_GAP, ST_POLL, ST_POLL_GAP, ST_WDS_CMD, ST_WDS_GAP
  } seq_st_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SET, PH_HIGH, PH_LOW} bit_ph_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_CTRL  = 2'b00;
  // deselect gap in phase ticks; 4 guarantees >= 3 full phases
  localparam int GAP_TICKS = 4;
endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(CLK_DIV);
      logic [DIV_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == DIV_W'(CLK_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == DIV_W'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/uwire_bit_engine.sv
module uwire_bit_engine
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int FRAME_W = 3 + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_W + 1),
  localparam int IN_W = $clog2(DATA_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nout_i,
  input  logic               rd_i,
  input  logic               di_i,
  output logic               done_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               cs_o,
  output logic               sk_o,
  output logic               do_o
);
  bit_ph_e            ph_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   out_left_q;
  logic [IN_W-1:0]    in_left_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               done_q;
  logic               last_bit;

  assign last_bit = (out_left_q == CNT_W'(1) && in_left_q == '0) ||
                    (out_left_q == '0 && in_left_q == IN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_IDLE;
      sh_q       <= '0;
      out_left_q <= '0;
      in_left_q  <= '0;
      rdata_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q       <= PH_SET;
          sh_q       <= frame_i;
          out_left_q <= nout_i;
          in_left_q  <= rd_i ? IN_W'(DATA_W) : '0;
        end
        PH_SET: if (tick_i) ph_q <= PH_HIGH;
        PH_HIGH: if (tick_i) begin
          ph_q <= PH_LOW;
          if (out_left_q == '0) rdata_q <= {rdata_q[DATA_W-2:0], di_i};
        end
        PH_LOW: if (tick_i) begin
          if (out_left_q != '0) begin
            out_left_q <= out_left_q - 1'b1;
            sh_q       <= sh_q << 1;
          end else begin
            in_left_q <= in_left_q - 1'b1;
          end
          if (last_bit) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            ph_q <= PH_SET;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cs_o    = (ph_q != PH_IDLE);
  assign sk_o    = (ph_q == PH_HIGH);
  assign do_o    = (ph_q != PH_IDLE) && (out_left_q != '0) && sh_q[FRAME_W-1];
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  a_r3_clock_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  a_r3_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> $stable(do_o));
  a_r3_done_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
endmodule

// File: rtl/uwire_eeprom_master.sv
module uwire_eeprom_master
  import uwire_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int POLL_TO = 4096,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int PT_W    = $clog2(POLL_TO + 1);
  localparam int GAP_W   = $clog2(GAP_TICKS + 1);

  seq_st_e            st_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               launched_q;
  logic [GAP_W-1:0]   gap_q;
  logic [PT_W-1:0]    poll_q;
  logic               err_pend_q, err_q, done_q;
  logic [DATA_W-1:0]  rdata_q;

  logic               tick;
  logic               is_cmd, eng_start, eng_done, eng_cs, eng_rd;
  logic [FRAME_W-1:0] eng_frame;
  logic [CNT_W-1:0]   eng_nout;
  logic [DATA_W-1:0]  eng_rdata;
  logic               gap_end;

  uwire_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  always_comb begin
    is_cmd    = 1'b1;
    eng_rd    = 1'b0;
    eng_nout  = CNT_W'(3 + ADDR_W);
    eng_frame = '0;
    unique case (st_q)
      ST_RD_CMD: begin
        eng_frame = {1'b1, OP_READ, addr_q, {DATA_W{1'b0}}};
        eng_rd    = 1'b1;
      end
      ST_WEN_CMD: eng_frame = {1'b1, OP_CTRL, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
      ST_WR_CMD: begin
        eng_frame = {1'b1, OP_WRITE, addr_q, wdata_q};
        eng_nout  = CNT_W'(FRAME_W);
      end
      ST_WDS_CMD: eng_frame = {1'b1, OP_CTRL, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
      default: is_cmd = 1'b0;
    endcase
  end

  assign eng_start = is_cmd && !launched_q;
  assign gap_end   = tick && (gap_q == GAP_W'(GAP_TICKS - 1));

  uwire_bit_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .start_i(eng_start),
    .frame_i(eng_frame), .nout_i(eng_nout), .rd_i(eng_rd), .di_i(di_i),
    .done_o(eng_done), .rdata_o(eng_rdata), .cs_o(eng_cs), .sk_o(sk_o),
    .do_o(do_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      launched_q <= 1'b0;
      gap_q      <= '0;
      poll_q     <= '0;
      err_pend_q <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (eng_start) launched_q <= 1'b1;
      if (tick) gap_q <= gap_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q     <= req_addr_i;
          wdata_q    <= req_wdata_i;
          err_pend_q <= 1'b0;
          err_q      <= 1'b0;
          st_q       <= req_write_i ? ST_WEN_CMD : ST_RD_CMD;
        end
        ST_RD_CMD, ST_WEN_CMD, ST_WR_CMD, ST_WDS_CMD: if (eng_done) begin
          launched_q <= 1'b0;
          gap_q      <= '0;
          unique case (st_q)
            ST_RD_CMD:  st_q <= ST_RD_GAP;
            ST_WEN_CMD: st_q <= ST_WEN_GAP;
            ST_WR_CMD:  st_q <= ST_WR_GAP;
            default:    st_q <= ST_WDS_GAP;
          endcase
        end
        ST_RD_GAP: if (gap_end) begin
          rdata_q <= eng_rdata;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        ST_WEN_GAP: if (gap_end) st_q <= ST_WR_CMD;
        ST_WR_GAP: if (gap_end) begin
          poll_q <= '0;
          st_q   <= ST_POLL;
        end
        ST_POLL: if (tick) begin
          if (di_i) begin
            gap_q <= '0;
            st_q  <= ST_POLL_GAP;
          end else if (poll_q == PT_W'(POLL_TO - 1)) begin
            err_pend_q <= 1'b1;
            gap_q      <= '0;
            st_q       <= ST_POLL_GAP;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        ST_POLL_GAP: if (gap_end) st_q <= ST_WDS_CMD;
        ST_WDS_GAP: if (gap_end) begin
          err_q  <= err_pend_q;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cs_o        = eng_cs || (st_q == ST_POLL);
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;

  a_r9_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));
  a_r11_err_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  a_r6_poll_no_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_POLL) |-> (cs_o && !sk_o));
  a_r8_done_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);
endmodule

// File: tb/uwire_eeprom_master_bench.sv
module uwire_eeprom_master_bench;
  localparam int CLK_DIV = 3;
  localparam int POLL_TO = 64;
  localparam int BUSY    = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, done, err, cs, sk, dout, di;
  logic [15:0] rdata;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uwire_eeprom_master #(.CLK_DIV(CLK_DIV), .POLL_TO(POLL_TO)) u_uwire_eeprom_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .rdata_o(rdata), .err_o(err), .cs_o(cs), .sk_o(sk),
    .do_o(dout), .di_i(di)
  );

  // device model
  logic [15:0] mem [256];
  logic m_pcs = 0, m_psk = 0, m_rd_act = 0, m_wen = 0, m_hang = 0, m_hang_busy = 0;
  logic [31:0] m_sh = '0;
  int m_bits = 0, m_busy = 0;
  logic [15:0] m_rd = '0;
  int lg_len [16];
  logic [31:0] lg_val [16];
  logic lg_busy [16];
  int lg_n = 0;

  assign di = m_rd_act ? m_rd[15] : (cs && m_busy == 0 && !m_hang_busy);

  always @(posedge clk) begin
    m_pcs <= cs;
    m_psk <= sk;
    if (m_busy > 0) m_busy <= m_busy - 1;
    if (cs && !m_pcs) begin
      m_sh <= '0;
      m_bits <= 0;
    end else if (cs && sk && !m_psk) begin
      m_sh <= {m_sh[30:0], dout};
      m_bits <= m_bits + 1;
    end
    if (cs && !sk && m_psk) begin
      if (m_bits == 11 && m_sh[10:8] == 3'b110) begin
        m_rd_act <= 1'b1;
        m_rd <= mem[m_sh[7:0]];
      end else if (m_rd_act) m_rd <= m_rd << 1;
    end
    if (!cs && m_pcs) begin
      if (lg_n < 16) begin
        lg_len[lg_n] <= m_bits;
        lg_val[lg_n] <= m_sh;
        lg_busy[lg_n] <= (m_busy != 0) || m_hang_busy;
      end
      lg_n <= lg_n + 1;
      m_rd_act <= 1'b0;
      if (m_bits == 11 && m_sh[10:8] == 3'b100) begin
        if (m_sh[7:6] == 2'b11) m_wen <= 1'b1;
        else if (m_sh[7:6] == 2'b00) m_wen <= 1'b0;
      end
      if (m_bits == 27 && m_sh[26:24] == 3'b101 && m_wen) begin
        mem[m_sh[23:16]] <= m_sh[15:0];
        if (m_hang) m_hang_busy <= 1'b1;
        else m_busy <= BUSY;
      end
    end
  end

  // R3 / R8 pin monitors
  int r3_bad = 0, r8_bad = 0, low_cnt = 0;
  logic seen_cmd = 0, p_sk = 0, p_do = 0, p_cs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sk && !cs) r3_bad++;
      if (sk && p_sk && dout != p_do) r3_bad++;
      if (cs && !p_cs) begin
        if (seen_cmd && low_cnt < 3 * CLK_DIV) r8_bad++;
        seen_cmd = 1'b1;
      end
      low_cnt = cs ? 0 : low_cnt + 1;
      p_sk = sk; p_do = dout; p_cs = cs;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [7:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output logic er);
    int n;
    bit ready_ok;
    @(negedge clk);
    lg_n = 0;
    chk(req_ready, "R9 ready high before request", req_ready, 1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    ready_ok = !req_ready;
    n = 0;
    while (!done && n < 20000) begin
      if (req_ready) ready_ok = 1'b0;
      @(negedge clk);
      n++;
    end
    chk(ready_ok && req_ready && done, "R9 ready low until done", {ready_ok, req_ready, done}, 3'b111);
    rd = rdata; er = err;
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(!cs && !sk && !dout, "R12 serial pins low", {cs, sk, dout}, 0);
    chk(req_ready && !done && !err, "R12 host outputs", {req_ready, done, err}, 3'b100);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [15:0] v);
    logic [15:0] rd;
    logic er;
    mem[a] = v;
    do_req(1'b0, a, 16'h0, rd, er);
    chk(rd == v, "R2 read data", rd, v);
    chk(lg_n == 1 && lg_len[0] == 27, "R2 read clocks", lg_len[0], 27);
    chk(lg_val[0][26:16] == {3'b110, a}, "R1 read command bits", lg_val[0][26:16], {3'b110, a});
  endtask

  task automatic t_write(input logic [7:0] a, input logic [15:0] v);
    logic [15:0] rd;
    logic er;
    do_req(1'b1, a, v, rd, er);
    chk(lg_n == 4, "R6 frame count", lg_n, 4);
    chk(lg_len[0] == 11 && lg_val[0][10:0] == 11'b100_1111_1111, "R4 enable frame",
        lg_val[0][10:0], 11'b100_1111_1111);
    chk(lg_len[1] == 27 && lg_val[1][26:0] == {3'b101, a, v}, "R5 program frame",
        lg_val[1][26:0], {3'b101, a, v});
    chk(lg_len[2] == 0 && !lg_busy[2], "R6 poll held until ready", {lg_len[2], lg_busy[2]}, 0);
    chk(lg_len[3] == 11 && lg_val[3][10:0] == 11'b100_0000_0000, "R7 disable frame",
        lg_val[3][10:0], 11'b100_0000_0000);
    chk(mem[a] == v && !er, "R5 word programmed", mem[a], v);
  endtask

  task automatic t_hold();
    logic [15:0] rd;
    logic er;
    t_read(8'h3c, 16'h5aa5);
    do_req(1'b1, 8'h3d, 16'h1234, rd, er);
    chk(rd == 16'h5aa5, "R10 read data held across write", rd, 16'h5aa5);
  endtask

  task automatic t_timeout();
    logic [15:0] rd;
    logic er;
    m_hang = 1'b1;
    do_req(1'b1, 8'h77, 16'hbeef, rd, er);
    chk(er == 1'b1, "R11 error on poll timeout", er, 1);
    chk(lg_n == 4 && lg_len[3] == 11 && lg_val[3][10:0] == 11'b100_0000_0000,
        "R11 disable still sent", lg_val[3][10:0], 11'b100_0000_0000);
    m_hang = 1'b0; m_hang_busy = 1'b0;
    do_req(1'b0, 8'h77, 16'h0, rd, er);
    chk(er == 1'b0 && rd == 16'hbeef, "R11 error cleared by next request", {er, rd}, {1'b0, 16'hbeef});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=busy expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read(8'h00, 16'ha5c3);
    t_read(8'hff, 16'hffff);
    t_read(8'h81, 16'h0000);
    t_read(8'h42, 16'h8001);
    t_write(8'h10, 16'hc0de);
    t_read(8'h10, 16'hc0de);
    t_write(8'hfe, 16'h0001);
    t_hold();
    t_timeout();
    chk(r3_bad == 0, "R3 bit phase discipline", r3_bad, 0);
    chk(r8_bad == 0, "R8 deselect gap", r8_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule